// File: doc/BRIEF.md
# Anti-Pop Output Ramp Sequencer

This block sequences the bias and enables of a single-ended, single-supply audio output stage so that power-up and power-down make no audible transient. After reset the output is clamped to ground. The sequencer first aligns to the sample clock. It then holds the clamp for a fixed number of sample periods. Next it drives a bias code that rises slowly from zero to full scale (the quiescent midpoint) over a long, parameterised number of sample periods. Only after that does it flag the audio path as valid.

A power-down request, taken from any phase, stops audio. It also detaches the output buffers and enables a slow discharge sink, so the external DC-blocking capacitors can bleed off. The block stays in that state until the next reset, so a reset pulse is the only control needed to start a new power-up. The sample-rate clock and the power-down request are both asynchronous to the system clock and are resynchronised inside the block. Only rising edges of the sample clock advance the sequence.

Top module: `outramp_seq`

## Requirements
- R1: While reset is low and right after its release, clamp_en=1, buf_en=0, sink_en=0, bias_code=0 and audio_ok=0.
- R2: The clamp stays on, with buf_en=0 and bias_code=0, through the first synchronised rising edge of lrck and HOLD_LEN further rising edges. lrck held high counts as one edge only.
- R3: During the ramp, clamp_en=0 and buf_en=1. After k rising edges of lrck inside the ramp, bias_code equals floor(k*(2^CODE_W-1)/RAMP_LEN).
- R4: During the ramp, bias_code never decreases, and it changes by at most ceil((2^CODE_W-1)/RAMP_LEN) per edge.
- R5: audio_ok rises on the RAMP_LEN-th ramp edge, together with bias_code reaching 2^CODE_W-1. Further lrck edges then change no output.
- R6: With pdn_req high, within three clock cycles sink_en=1, clamp_en=0, buf_en=0 and audio_ok=0, from any phase. bias_code is 0 one cycle later.
- R7: Once in discharge, releasing pdn_req and toggling lrck leave all outputs unchanged until reset.
- R8: Reset low from any phase returns the outputs to the R1 values, and the sequence restarts from the first lrck edge.
- R9: At most one of clamp_en, buf_en and sink_en is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts power-up |
| pdn_req | input | 1 | Power-down request, asynchronous level |
| lrck | input | 1 | Sample-rate clock, asynchronous |
| clamp_en | output | 1 | Clamp the outputs to ground |
| buf_en | output | 1 | Connect the output buffers |
| sink_en | output | 1 | Enable the discharge current sink |
| bias_code | output | CODE_W | Bias ramp code, 0 = ground, all ones = quiescent level |
| audio_ok | output | 1 | Audio path may pass samples |

## Verification
The bench builds two instances with HOLD_LEN=3 and RAMP_LEN=10. One has CODE_W=4, so each ramp step is one or two codes. The other has CODE_W=3, where the full scale is smaller than the ramp length and some edges leave the code unchanged. These short lengths let every edge of the whole power-up sequence be checked against floor(k*full/RAMP_LEN), both boundaries included. They also make it cheap to enter power-down and reset from each phase in turn.

// File: rtl/outramp_pkg.sv
package outramp_pkg;

  typedef enum logic [2:0] {
    PH_CLAMP = 3'd0,
    PH_WAIT  = 3'd1,
    PH_RAMP  = 3'd2,
    PH_RUN   = 3'd3,
    PH_DISCH = 3'd4
  } phase_t;

  // Remainder overflow of the fractional ramp accumulator.
  function automatic logic ramp_carry(input logic [31:0] rem,
                                      input logic [31:0] frac,
                                      input logic [31:0] len);
    return (rem + frac) >= len;
  endfunction

  function automatic logic [31:0] ramp_next_rem(input logic [31:0] rem,
                                                input logic [31:0] frac,
                                                input logic [31:0] len);
    logic [31:0] s;
    s = rem + frac;
    return (s >= len) ? (s - len) : s;
  endfunction

  function automatic logic [31:0] ramp_next_code(input logic [31:0] code,
                                                 input logic [31:0] whole,
                                                 input logic        carry);
    return code + whole + {31'd0, carry};
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ramp_accum.sv
module ramp_accum
  import outramp_pkg::*;
#(
  parameter int CODE_W   = 14,
  parameter int RAMP_LEN = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [CODE_W-1:0] code
);
  localparam logic [31:0] FULL  = (32'd1 << CODE_W) - 32'd1;
  localparam logic [31:0] LEN   = RAMP_LEN;
  localparam logic [31:0] WHOLE = FULL / LEN;
  localparam logic [31:0] FRAC  = FULL % LEN;
  localparam int          REM_W = $clog2(2 * RAMP_LEN);

  logic [REM_W-1:0] rem;
  logic             step_carry;

  assign step_carry = ramp_carry(32'(rem), FRAC, LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      rem  <= '0;
    end else if (clr) begin
      code <= '0;
      rem  <= '0;
    end else if (step) begin
      code <= CODE_W'(ramp_next_code(32'(code), WHOLE, step_carry));
      rem  <= REM_W'(ramp_next_rem(32'(rem), FRAC, LEN));
    end
  end

  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (code >= $past(code)));

  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (32'(code) - 32'($past(code)) <= WHOLE + 32'd1));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(code));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import outramp_pkg::*;
#(
  parameter int HOLD_LEN = 1000,
  parameter int RAMP_LEN = 10000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lrck_rise,
  input  logic   pdn_s,
  output phase_t phase,
  output logic   ramp_step,
  output logic   ramp_clr
);
  localparam int MAXLEN = (HOLD_LEN > RAMP_LEN) ? HOLD_LEN : RAMP_LEN;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_t           phase_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             hold_done, ramp_done;

  assign hold_done = (cnt == CNT_W'(HOLD_LEN - 1));
  assign ramp_done = (cnt == CNT_W'(RAMP_LEN - 1));

  always_comb begin
    phase_nxt = phase;
    cnt_nxt   = cnt;
    if (pdn_s) begin
      phase_nxt = PH_DISCH;
      cnt_nxt   = '0;
    end else begin
      case (phase)
        PH_CLAMP: if (lrck_rise) begin
          phase_nxt = PH_WAIT;
          cnt_nxt   = '0;
        end
        PH_WAIT: if (lrck_rise) begin
          if (hold_done) begin
            phase_nxt = PH_RAMP;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        PH_RAMP: if (lrck_rise) begin
          if (ramp_done) begin
            phase_nxt = PH_RUN;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CLAMP;
      cnt   <= '0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
    end
  end

  assign ramp_step = lrck_rise && !pdn_s && (phase == PH_RAMP);
  assign ramp_clr  = (phase == PH_CLAMP) || (phase == PH_WAIT) || (phase == PH_DISCH);

  a_r6_pdn_enters: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_s |=> (phase == PH_DISCH));

  a_r7_disch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DISCH) |=> (phase == PH_DISCH));

  a_r2_clamp_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLAMP && lrck_rise && !pdn_s) |=> (phase == PH_WAIT));

  a_r5_run_from_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |-> ($past(phase) == PH_RUN || $past(phase) == PH_RAMP));
endmodule

// File: rtl/outramp_seq.sv
module outramp_seq
  import outramp_pkg::*;
#(
  parameter int CODE_W      = 14,
  parameter int HOLD_LEN    = 1000,
  parameter int RAMP_LEN    = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_req,
  input  logic              lrck,
  output logic              clamp_en,
  output logic              buf_en,
  output logic              sink_en,
  output logic [CODE_W-1:0] bias_code,
  output logic              audio_ok
);
  localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

  logic   lrck_s, lrck_d, lrck_rise;
  logic   pdn_s;
  logic   ramp_step, ramp_clr;
  phase_t phase;

  sync_chain #(.STAGES(SYNC_STAGES)) u_lrck_sync (
    .clk(clk), .rst_n(rst_n), .d(lrck), .q(lrck_s));

  sync_chain #(.STAGES(SYNC_STAGES)) u_pdn_sync (
    .clk(clk), .rst_n(rst_n), .d(pdn_req), .q(pdn_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lrck_d <= 1'b0;
    else        lrck_d <= lrck_s;

  assign lrck_rise = lrck_s && !lrck_d;

  seq_fsm #(.HOLD_LEN(HOLD_LEN), .RAMP_LEN(RAMP_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lrck_rise(lrck_rise), .pdn_s(pdn_s),
    .phase(phase), .ramp_step(ramp_step), .ramp_clr(ramp_clr));

  ramp_accum #(.CODE_W(CODE_W), .RAMP_LEN(RAMP_LEN)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .step(ramp_step),
    .code(bias_code));

  assign clamp_en = (phase == PH_CLAMP) || (phase == PH_WAIT);
  assign buf_en   = (phase == PH_RAMP) || (phase == PH_RUN);
  assign sink_en  = (phase == PH_DISCH);
  assign audio_ok = (phase == PH_RUN);

  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_rise |=> !lrck_rise);

  a_r5_audio_full: assert property (@(posedge clk) disable iff (!rst_n)
    audio_ok |-> (bias_code == FULL_CODE));

  a_r2_clamp_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && $past(clamp_en)) |-> (bias_code == '0));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clamp_en, buf_en, sink_en}));

  a_r6_disch_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_en && $past(sink_en)) |-> (bias_code == '0));
endmodule

// File: tb/test_outramp_seq.sv
`timescale 1ns/1ps
module test_outramp_seq;
  localparam int HOLD = 3;
  localparam int RLEN = 10;
  localparam int WA   = 4;
  localparam int WB   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdn_req = 1'b0;
  logic lrck = 1'b0;

  logic          clamp_a, buf_a, sink_a, ok_a;
  logic [WA-1:0] code_a;
  logic          clamp_b, buf_b, sink_b, ok_b;
  logic [WB-1:0] code_b;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  outramp_seq #(.CODE_W(WA), .HOLD_LEN(HOLD), .RAMP_LEN(RLEN)) i_outramp_seq (
    .clk(clk), .rst_n(rst_n), .pdn_req(pdn_req), .lrck(lrck),
    .clamp_en(clamp_a), .buf_en(buf_a), .sink_en(sink_a),
    .bias_code(code_a), .audio_ok(ok_a));

  outramp_seq #(.CODE_W(WB), .HOLD_LEN(HOLD), .RAMP_LEN(RLEN)) i_outramp_seq_narrow (
    .clk(clk), .rst_n(rst_n), .pdn_req(pdn_req), .lrck(lrck),
    .clamp_en(clamp_b), .buf_en(buf_b), .sink_en(sink_b),
    .bias_code(code_b), .audio_ok(ok_b));

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // n = synchronised lrck rising edges since reset; disch = power-down taken
  task automatic check_state(input string req, input int n, input bit disch);
    int k, ec, ebuf, eok, eca, ecb;
    ec = 0; ebuf = 0; eok = 0; eca = 0; ecb = 0;
    if (!disch) begin
      if (n <= HOLD) begin
        ec = 1;
      end else begin
        k = n - HOLD - 1;
        if (k > RLEN) k = RLEN;
        ebuf = 1;
        eok  = (k >= RLEN) ? 1 : 0;
        eca  = k * ((1 << WA) - 1) / RLEN;
        ecb  = k * ((1 << WB) - 1) / RLEN;
      end
    end
    check_val({req, " clamp_en"},  int'(clamp_a), ec);
    check_val({req, " buf_en"},    int'(buf_a),   ebuf);
    check_val({req, " sink_en"},   int'(sink_a),  disch ? 1 : 0);
    check_val({req, " audio_ok"},  int'(ok_a),    eok);
    check_val({req, " bias_code"}, int'(code_a),  eca);
    check_val({req, " narrow clamp_en"},  int'(clamp_b), ec);
    check_val({req, " narrow buf_en"},    int'(buf_b),   ebuf);
    check_val({req, " narrow sink_en"},   int'(sink_b),  disch ? 1 : 0);
    check_val({req, " narrow audio_ok"},  int'(ok_b),    eok);
    check_val({req, " narrow bias_code"}, int'(code_b),  ecb);
    // R9: enables mutually exclusive
    check_val("R9 one enable a", int'(clamp_a) + int'(buf_a) + int'(sink_a), 1);
    check_val("R9 one enable b", int'(clamp_b) + int'(buf_b) + int'(sink_b), 1);
  endtask

  task automatic lrck_edge(input int high_clks);
    @(negedge clk) lrck = 1'b1;
    repeat (high_clks) @(posedge clk);
    @(negedge clk) lrck = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) begin rst_n = 1'b0; pdn_req = 1'b0; lrck = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic power_down();
    @(negedge clk) pdn_req = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_state("R1 in reset", 0, 1'b0);
    do_reset();
    check_state("R1 after reset", 0, 1'b0);

    // R2 R3 R4 R5: full power-up sweep, one long-high edge in the hold
    for (int n = 1; n <= HOLD + RLEN + 3; n++) begin
      lrck_edge(n == 2 ? 20 : 5);
      if (n <= HOLD)             check_state("R2 hold", n, 1'b0);
      else if (n <= HOLD + RLEN) check_state("R3 R4 ramp", n, 1'b0);
      else                       check_state("R5 run", n, 1'b0);
    end

    // R6 from run, then R7 sticky
    power_down();
    check_state("R6 pdn in run", 0, 1'b1);
    @(negedge clk) pdn_req = 1'b0;
    for (int i = 0; i < 3; i++) lrck_edge(5);
    check_state("R7 sticky", 0, 1'b1);

    // R8 reset from discharge
    do_reset();
    check_state("R8 reset from disch", 0, 1'b0);

    // R6 from clamp
    power_down();
    check_state("R6 pdn in clamp", 0, 1'b1);

    // R6 from wait
    do_reset();
    lrck_edge(5); lrck_edge(5);
    check_state("R2 wait again", 2, 1'b0);
    power_down();
    check_state("R6 pdn in wait", 0, 1'b1);

    // R6 mid-ramp
    do_reset();
    for (int n = 1; n <= HOLD + 6; n++) lrck_edge(5);
    check_state("R3 mid ramp", HOLD + 6, 1'b0);
    power_down();
    check_state("R6 pdn in ramp", 0, 1'b1);

    // R8 reset mid-ramp, then restart counts from first edge
    do_reset();
    for (int n = 1; n <= HOLD + 4; n++) lrck_edge(5);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_state("R8 reset mid ramp", 0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int n = 1; n <= HOLD + 2; n++) lrck_edge(5);
    check_state("R8 restart", HOLD + 2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule